// File: doc/BRIEF.md
# Programmable Post-Divider with Glitch-Free Output Stop

This block sits between a fast oscillator clock and the output stage of a clock synthesizer. A two-bit code selects a power-of-two division ratio of 1, 2, 4 or 8. The block produces a true and complement clock pair at the divided rate. With the default code width, the four codes give output bands of 200–400, 100–200, 50–100 and 25–50 MHz from a 200–400 MHz oscillator. Every ratio keeps a 50% duty cycle. For ratio 1 the output is the input clock, passed through a gate that opens or closes only while the clock is low.

An output-enable request is brought into the clock domain through a flop synchroniser. It then takes effect only on a boundary of the divided clock, so stopping or starting the output never shortens a pulse. While stopped, the pair is parked with the true output low and the complement high. A new ratio code is applied only where the divided output falls at the end of a period, or at once if the output is parked. The new ratio then starts from a cleared counter with a full low half.

Top module: `clk_post_divider`

## Requirements
- R1: Code 00 divides the input clock by 1, code 01 by 2, code 10 by 4 and code 11 by 8. The code is read as an unsigned binary value.
- R2: At ratios 2, 4 and 8 the true output is high for exactly half the ratio in input cycles and low for the other half. At ratio 1 it is high exactly while the input clock is high.
- R3: The complement output is always the inverse of the true output.
- R4: The enable request passes through a two-flop synchroniser. Once it is off, the output completes any high phase already begun and then parks with the true output low and the complement high.
- R5: When the output is turned on at ratios 2, 4 or 8, the change waits for the low half of the divided clock, so the first high phase has full length.
- R6: While the output is running, a changed code is applied only at the edge that ends the current period. That edge clears the counter, and the new ratio begins with its low half.
- R7: While the output is parked, a changed code is applied at the next rising edge of the input clock.
- R8: During reset the true output is low and the complement high. After reset is released, the ratio is 1 and the counter starts from zero.
- R9: At ratio 1 the enable and the ratio-1 path select are taken on the falling clock edge. When the output switches between the ratio-1 path and the divided path, that switch happens while both paths are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast oscillator clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ratio_sel_i | input | CODE_W | Division ratio code (ratio = 2^code) |
| out_en_i | input | 1 | Output enable request, asynchronous |
| fout_o | output | 1 | Divided clock, true polarity |
| fout_n_o | output | 1 | Divided clock, complement polarity |

## Verification
A behavioural model advances a phase counter at each clock edge, and the bench compares the outputs against it half a cycle apart, so the high and low halves of ratio 1 are both seen. Each ratio is held steady for a counting window. Counting highs and rising edges in that window separates a wrong ratio from a wrong duty cycle. The enable is toggled at varying offsets into the period, which shows whether pulses are clipped or delayed by a whole period. Ratio changes are made mid-period while running, while parked, and between the bypass path and the divided path. These cases tell deferred application apart from immediate application, and show whether the path switch is clean.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;
    localparam int unsigned PDIV_CODE_W_DEF = 2;
    localparam int unsigned PDIV_SYNC_DEF   = 2;

    typedef enum logic [1:0] {
        PDIV_BY1 = 2'b00,
        PDIV_BY2 = 2'b01,
        PDIV_BY4 = 2'b10,
        PDIV_BY8 = 2'b11
    } pdiv_code_e;
endpackage

// File: rtl/pdiv_oe_sync.sv
module pdiv_oe_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_i,
    output logic req_s_o
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
    } sync_st_t;

    sync_st_t st_d, st_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb begin
                st_d    = st_q;
                st_d.sh = req_i;
            end
        end else begin : g_many
            always_comb begin
                st_d    = st_q;
                st_d.sh = {st_q.sh[STAGES-2:0], req_i};
            end
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign req_s_o = st_q.sh[STAGES-1];
endmodule

// File: rtl/pdiv_ratio_ctrl.sv
module pdiv_ratio_ctrl #(
    parameter int unsigned CODE_W = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CODE_W-1:0] code_i,
    input  logic              oe_s_i,
    output logic [CODE_W-1:0] sel_o,
    output logic              div_o
);
    localparam int unsigned CNT_W = (1 << CODE_W) - 1;
    localparam int unsigned HR_W  = CNT_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [CODE_W-1:0] sel;
        logic              gate;
        logic              div;
        logic [HR_W-1:0]   hi_run;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    function automatic logic [CNT_W-1:0] low_mask(input logic [CODE_W-1:0] s);
        logic [CNT_W-1:0] m;
        m = '0;
        for (int i = 0; i < int'(CNT_W); i++)
            if (i < int'(s)) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic tap(input logic [CNT_W-1:0] c, input logic [CODE_W-1:0] s);
        logic t;
        t = 1'b0;
        for (int i = 0; i < int'(CNT_W); i++)
            if (int'(s) == i + 1) t = c[i];
        return t;
    endfunction

    function automatic logic [HR_W-1:0] half_of(input logic [CODE_W-1:0] s);
        logic [HR_W-1:0] h;
        h = '0;
        for (int i = 1; i <= int'(CNT_W); i++)
            if (int'(s) == i) h = HR_W'(1) << (i - 1);
        return h;
    endfunction

    logic [CNT_W-1:0] mask_q;
    logic             period_end;
    logic             take;
    logic             raw_d;

    always_comb begin
        mask_q     = low_mask(st_q.sel);
        period_end = ((st_q.cnt & mask_q) == mask_q);
        take       = (code_i != st_q.sel) && (period_end || !st_q.gate);
        st_d       = st_q;
        if (take) begin
            st_d.sel = code_i;
            st_d.cnt = '0;
        end else if (period_end) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        raw_d       = tap(st_d.cnt, st_d.sel);
        st_d.gate   = raw_d ? st_q.gate : oe_s_i;
        st_d.div    = raw_d & st_d.gate;
        st_d.hi_run = st_d.div ? st_q.hi_run + HR_W'(1) : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sel_o = st_q.sel;
    assign div_o = st_q.div;

    logic [HR_W-1:0] half_now;
    assign half_now = half_of(st_q.sel);

    // R2
    hi_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(st_q.div) |-> ($past(st_q.hi_run) == $past(half_now)))
        else $error("high phase length differs from half the ratio");

    // R6
    sel_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.sel != $past(st_q.sel)) |-> (st_q.cnt == '0 && !st_q.div))
        else $error("ratio changed away from a period start");

    // R7
    idle_apply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!st_q.gate && code_i != st_q.sel) |=> (st_q.sel == $past(code_i)))
        else $error("parked ratio change not applied");

    // R4
    park_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!oe_s_i && !st_q.gate) |=> !st_q.div)
        else $error("divided output left park while disabled");
endmodule

// File: rtl/pdiv_out_gate.sv
module pdiv_out_gate #(
    parameter int unsigned CODE_W = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CODE_W-1:0] sel_i,
    input  logic              oe_s_i,
    input  logic              div_i,
    output logic              out_t_o,
    output logic              out_n_o
);
    typedef struct packed {
        logic is1;
        logic g1;
    } gate_st_t;

    gate_st_t st_d, st_q;
    logic     bypass;

    always_comb begin
        bypass = (sel_i == '0);
        st_d     = st_q;
        st_d.is1 = bypass;
        st_d.g1  = oe_s_i;
    end

    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.is1 <= 1'b1;
            st_q.g1  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_t_o = st_q.is1 ? (clk_i & st_q.g1) : div_i;
    assign out_n_o = ~out_t_o;

    // R9
    mux_switch_low_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
        (bypass != st_q.is1) |-> !div_i)
        else $error("path switch while divided path high");
endmodule

// File: rtl/clk_post_divider.sv
module clk_post_divider
    import pdiv_pkg::*;
#(
    parameter int unsigned CODE_W      = PDIV_CODE_W_DEF,
    parameter int unsigned SYNC_STAGES = PDIV_SYNC_DEF
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CODE_W-1:0] ratio_sel_i,
    input  logic              out_en_i,
    output logic              fout_o,
    output logic              fout_n_o
);
    logic              oe_s;
    logic [CODE_W-1:0] sel;
    logic              div;

    pdiv_oe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .req_i   (out_en_i),
        .req_s_o (oe_s)
    );

    pdiv_ratio_ctrl #(.CODE_W(CODE_W)) u_ctrl (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .code_i (ratio_sel_i),
        .oe_s_i (oe_s),
        .sel_o  (sel),
        .div_o  (div)
    );

    pdiv_out_gate #(.CODE_W(CODE_W)) u_gate (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .sel_i   (sel),
        .oe_s_i  (oe_s),
        .div_i   (div),
        .out_t_o (fout_o),
        .out_n_o (fout_n_o)
    );

    // R8
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            reset_park_chk: assert (!fout_o && fout_n_o)
                else $error("output not parked during reset");
        end
    end
endmodule

// File: tb/clk_post_divider_tb_top.sv
module clk_post_divider_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] code = 2'b00;
    logic       oe = 1'b0;
    logic       fout, fout_n;

    int total = 0;
    int bad = 0;
    string cur_req = "R8";

    always #5 clk = ~clk;

    clk_post_divider dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .ratio_sel_i (code),
        .out_en_i    (oe),
        .fout_o      (fout),
        .fout_n_o    (fout_n)
    );

    // behavioural reference: phase within period, enable latch, bypass path
    int m_ratio = 1;
    int m_phase = 0;
    bit m_on = 0, m_out = 0, m_s0 = 0, m_s1 = 0, m_is1 = 1, m_g1 = 0;

    always @(posedge clk or negedge rst_n) begin : model_rise
        bit oes, endp, nh;
        int want;
        if (!rst_n) begin
            m_ratio = 1; m_phase = 0; m_on = 0; m_out = 0; m_s0 = 0; m_s1 = 0;
        end else begin
            oes  = m_s1;
            m_s1 = m_s0;
            m_s0 = oe;
            want = 1 << code;
            endp = (m_phase == m_ratio - 1);
            if (want != m_ratio && (endp || !m_on)) begin
                m_ratio = want;
                m_phase = 0;
            end else begin
                m_phase = endp ? 0 : m_phase + 1;
            end
            nh = (m_ratio > 1) && (m_phase >= m_ratio / 2);
            if (!nh) m_on = oes;
            m_out = nh && m_on;
        end
    end

    always @(negedge clk or negedge rst_n) begin : model_fall
        if (!rst_n) begin
            m_is1 = 1; m_g1 = 0;
        end else begin
            m_is1 = (m_ratio == 1);
            m_g1  = m_s1;
        end
    end

    function automatic bit expect_t();
        return m_is1 ? (clk && m_g1) : m_out;
    endfunction

    task automatic check(input string req, input logic act, input logic exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s at %0t: actual=%b expected=%b", req, what, $time, act, exp);
        end
    endtask

    task automatic compare_now();
        bit e;
        e = expect_t();
        check(cur_req, fout, e, "true output vs model");
        check("R3", fout_n, ~e, "complement output");
    endtask

    always @(posedge clk) begin #2; compare_now(); end
    always @(negedge clk) begin #2; compare_now(); end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // R1 / R2: count highs and rises over a 64-cycle window
    task automatic measure(input int ratio);
        int hi, rises, lowhi;
        logic prev, s;
        hi = 0; rises = 0; lowhi = 0;
        @(posedge clk); #2; prev = fout;
        for (int i = 0; i < 64; i++) begin
            @(posedge clk); #2; s = fout;
            if (s) hi++;
            if (s && !prev) rises++;
            prev = s;
            @(negedge clk); #2;
            if (fout) lowhi++;
        end
        if (ratio == 1) begin
            check("R1", (hi == 64), 1'b1, "ratio 1 follows clock high");
            check("R2", (lowhi == 0), 1'b1, "ratio 1 low while clock low");
        end else begin
            check("R1", (rises == 64 / ratio), 1'b1, $sformatf("rise count %0d ratio %0d", rises, ratio));
            check("R2", (hi == 32), 1'b1, $sformatf("high count %0d ratio %0d", hi, ratio));
            check("R2", (lowhi == 32), 1'b1, "high count in low half samples");
        end
    endtask

    task automatic park_check(input string req);
        @(posedge clk); #2;
        check(req, fout, 1'b0, "parked true output (high half)");
        check(req, fout_n, 1'b1, "parked complement output");
        @(negedge clk); #2;
        check(req, fout, 1'b0, "parked true output (low half)");
    endtask

    initial begin : watchdog
        #(20000 * 10);
        total++;
        bad++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        // R8: reset state
        cur_req = "R8";
        repeat (3) @(posedge clk);
        #2;
        check("R8", fout, 1'b0, "true output in reset");
        check("R8", fout_n, 1'b1, "complement output in reset");
        step(1);
        rst_n = 1'b1;
        step(5);
        park_check("R8");

        // R1, R2: every ratio steady
        for (int c = 0; c < 4; c++) begin
            cur_req = "R1";
            code = 2'(c);
            oe = 1'b1;
            step(20);
            measure(1 << c);
        end

        // R6: mid-period ratio changes while running
        cur_req = "R6";
        code = 2'b11; step(21);
        code = 2'b01; step(20);
        code = 2'b10; step(3);
        code = 2'b11; step(30);
        code = 2'b00; step(5);
        code = 2'b01; step(1);
        code = 2'b00; step(6);
        code = 2'b11; step(20);

        // R4: disable mid-period
        cur_req = "R4";
        step(5);
        oe = 1'b0; step(20);
        park_check("R4");

        // R7: ratio change while parked
        cur_req = "R7";
        code = 2'b01; step(2);
        code = 2'b10; step(3);
        park_check("R7");

        // R5: enable at varied offsets
        cur_req = "R5";
        oe = 1'b1; step(13);
        oe = 1'b0; step(7);
        oe = 1'b1; step(3);
        oe = 1'b0; step(2);
        oe = 1'b1; step(25);

        // R9: bypass gating
        cur_req = "R9";
        code = 2'b00; step(10);
        oe = 1'b0; step(7);
        park_check("R9");
        oe = 1'b1; step(9);
        code = 2'b10; step(12);
        code = 2'b00; step(8);

        // R8: reset in the middle of operation
        cur_req = "R8";
        code = 2'b11; step(13);
        rst_n = 1'b0; #2;
        check("R8", fout, 1'b0, "true output right after reset assert");
        step(3);
        rst_n = 1'b1;
        step(30);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule